// File: doc/BRIEF.md
# Link Power State Controller

This block keeps track of the power level of one serial link port. The four levels are active, fast-exit idle, slow-exit idle and suspend. The link leaves active on its own after programmable stretches of inactivity, when the link partner asks for a low-power level, or when software commands suspend. It goes back to active on real traffic or on a local wake request, after an exit latency that depends on the level being left.

The controller watches traffic indications and ignores the timestamp class for all timing and wake purposes. It holds the link active while a transfer is pending, and it answers partner requests with one-cycle accept or reject pulses. It drives the PLL enable, a wake-request flag that is high for the whole exit, and a device-suspend flag. Every pin is a plain level or pulse sampled on the rising clock edge. No data stream passes through the block, so it has no valid/ready interfaces and no back-pressure.

Top module: `link_pm_ctrl`

## Requirements
- R1: After reset, link_state is 0, pll_en is 1, and wake_req, dev_suspended, partner_ack and partner_rej are all 0.
- R2: link_state encodes the level as 0 for active, 1 for fast-exit idle, 2 for slow-exit idle and 3 for suspend. pll_en is 1 in levels 0 and 1 and during any exit, and 0 in levels 2 and 3 otherwise.
- R3: In level 0, each cycle with no non-timestamp traffic, no pending transfer, no partner request and no suspend command adds one to an idle count. Any such event clears the count. When the count reaches a nonzero u1_timeout, the link enters level 1 on that edge. A zero u1_timeout never enters level 1 by timer.
- R4: The idle count keeps running in level 1 and does not restart there. When the count reaches a nonzero u2_timeout, the link enters level 2. If u1_timeout is 0 and u2_timeout is nonzero, level 0 goes straight to level 2 when the count reaches u2_timeout. A zero u2_timeout disables level 2 by timer.
- R5: A traffic indication with traffic_is_ts=1 neither clears nor restarts the idle count, and it wakes no idle level.
- R6: While xfer_pending is 1 in level 0, the idle count stays at zero and the link stays in level 0. In level 1 or level 2, xfer_pending starts an exit.
- R7: Non-timestamp traffic or wake_in in level 1, 2 or 3 starts an exit. From the next edge, wake_req is 1 and link_state still shows the level being left. link_state becomes 0 and wake_req falls exactly L+1 edges after the wake edge, where L is the exit latency.
- R8: L is exit_lat_fast when leaving level 1, and exit_lat_slow when leaving level 2 or level 3.
- R9: sw_suspend in settled level 0 moves the link to level 3 on the next edge and takes priority over all other inputs. sw_suspend is ignored in every other level. dev_suspended is 1 exactly while link_state is 3, including the exit from level 3.
- R10: A partner request in settled level 0 is accepted only if partner_req_lvl is 1 or 2 and neither tx_queued nor xfer_pending is set. On accept, partner_ack pulses for one cycle together with the move to that level, and the idle count restarts from 0. Otherwise partner_rej pulses for one cycle and the link stays in level 0. Requests outside settled level 0 produce neither pulse.
- R11: In settled level 0 the priority is suspend command, then partner request, then traffic or pending, then the idle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| traffic_vld | input | 1 | A packet moved on the link this cycle |
| traffic_is_ts | input | 1 | The packet this cycle is a timestamp packet |
| xfer_pending | input | 1 | Host reports outstanding transfers |
| tx_queued | input | 1 | Local traffic is waiting to be sent |
| partner_req_vld | input | 1 | Link partner asks for a low-power level |
| partner_req_lvl | input | 2 | Level the partner asks for |
| sw_suspend | input | 1 | Software suspend command |
| wake_in | input | 1 | Local wake request |
| u1_timeout | input | TW | Idle cycles before level 1, 0 disables |
| u2_timeout | input | TW | Idle cycles before level 2, 0 disables |
| exit_lat_fast | input | LW | Exit latency from level 1 |
| exit_lat_slow | input | LW | Exit latency from level 2 or 3 |
| link_state | output | 2 | Current level code |
| pll_en | output | 1 | PLL enable |
| wake_req | output | 1 | Exit to level 0 in progress |
| dev_suspended | output | 1 | Device is in suspend |
| partner_ack | output | 1 | Partner request accepted (pulse) |
| partner_rej | output | 1 | Partner request rejected (pulse) |

## Verification
The hardest situation to reach from the ports is a level 1 to level 2 move that happens while timestamp packets keep arriving. It needs a long unbroken run of idle cycles in which only timestamp traffic appears, followed by the exact edge where the carried-over count reaches u2_timeout. Directed sequences program small timeouts, keep the other inputs quiet and inject timestamp pulses across the level 0, level 1 and level 2 span. A seeded random phase then mixes every input at low rates, so that timer expiry, partner handshakes and exits collide. Every cycle is compared with a cycle model kept inside the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE    = 2'd0,
    LS_FAST_IDLE = 2'd1,
    LS_SLOW_IDLE = 2'd2,
    LS_SUSPEND   = 2'd3
  } lpm_state_e;

  function automatic logic lvl_is_idle(input logic [1:0] lvl);
    return (lvl == 2'd1) || (lvl == 2'd2);
  endfunction
endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [TW-1:0] u1_lim,
  input  logic [TW-1:0] u2_lim,
  output logic          hit_u1,
  output logic          hit_u2
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_inc;

  // saturating next count, used for expiry compare on the same edge
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign hit_u1  = (u1_lim != '0) && (cnt_inc >= u1_lim);
  assign hit_u2  = (u2_lim != '0) && (cnt_inc >= u2_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/lpm_exit_timer.sv
module lpm_exit_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] lat,
  output logic          busy,
  output logic          done
);
  logic [LW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= lat;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lpm_partner_gate.sv
module lpm_partner_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eval,
  input  logic       req_vld,
  input  logic [1:0] req_lvl,
  input  logic       tx_queued,
  input  logic       xfer_pending,
  output logic       accept,
  output logic       ack,
  output logic       rej
);
  import lpm_pkg::*;

  assign accept = eval && req_vld && lvl_is_idle(req_lvl) &&
                  !tx_queued && !xfer_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      rej <= 1'b0;
    end else begin
      ack <= accept;
      rej <= eval && req_vld && !accept;
    end
  end
endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl #(
  parameter int TW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          traffic_vld,
  input  logic          traffic_is_ts,
  input  logic          xfer_pending,
  input  logic          tx_queued,
  input  logic          partner_req_vld,
  input  logic [1:0]    partner_req_lvl,
  input  logic          sw_suspend,
  input  logic          wake_in,
  input  logic [TW-1:0] u1_timeout,
  input  logic [TW-1:0] u2_timeout,
  input  logic [LW-1:0] exit_lat_fast,
  input  logic [LW-1:0] exit_lat_slow,
  output logic [1:0]    link_state,
  output logic          pll_en,
  output logic          wake_req,
  output logic          dev_suspended,
  output logic          partner_ack,
  output logic          partner_rej
);
  import lpm_pkg::*;

  lpm_state_e    st_q, st_d;
  logic          idle_clr, idle_inc, hit_u1, hit_u2;
  logic          ex_start, ex_busy, ex_done;
  logic [LW-1:0] ex_lat;
  logic          pg_eval, pg_accept;
  logic          activity;

  assign activity = traffic_vld && !traffic_is_ts;
  assign pg_eval  = !ex_busy && (st_q == LS_ACTIVE) && !sw_suspend;

  lpm_idle_timer #(.TW(TW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .inc(idle_inc),
    .u1_lim(u1_timeout), .u2_lim(u2_timeout),
    .hit_u1(hit_u1), .hit_u2(hit_u2)
  );

  lpm_exit_timer #(.LW(LW)) u_exit (
    .clk(clk), .rst_n(rst_n), .start(ex_start), .lat(ex_lat),
    .busy(ex_busy), .done(ex_done)
  );

  lpm_partner_gate u_gate (
    .clk(clk), .rst_n(rst_n), .eval(pg_eval),
    .req_vld(partner_req_vld), .req_lvl(partner_req_lvl),
    .tx_queued(tx_queued), .xfer_pending(xfer_pending),
    .accept(pg_accept), .ack(partner_ack), .rej(partner_rej)
  );

  always_comb begin
    st_d     = st_q;
    idle_clr = 1'b0;
    idle_inc = 1'b0;
    ex_start = 1'b0;
    ex_lat   = exit_lat_slow;
    if (ex_busy) begin
      if (ex_done) begin
        st_d     = LS_ACTIVE;
        idle_clr = 1'b1;
      end
    end else begin
      unique case (st_q)
        LS_ACTIVE: begin
          if (sw_suspend) begin
            st_d     = LS_SUSPEND;
            idle_clr = 1'b1;
          end else if (partner_req_vld) begin
            idle_clr = 1'b1;
            if (pg_accept) st_d = lpm_state_e'(partner_req_lvl);
          end else if (activity || xfer_pending) begin
            idle_clr = 1'b1;
          end else begin
            idle_inc = 1'b1;
            if (hit_u1)                              st_d = LS_FAST_IDLE;
            else if ((u1_timeout == '0) && hit_u2)   st_d = LS_SLOW_IDLE;
          end
        end
        LS_FAST_IDLE, LS_SLOW_IDLE: begin
          if (activity || wake_in || xfer_pending) begin
            ex_start = 1'b1;
            ex_lat   = (st_q == LS_FAST_IDLE) ? exit_lat_fast : exit_lat_slow;
          end else if (st_q == LS_FAST_IDLE) begin
            idle_inc = 1'b1;
            if (hit_u2) st_d = LS_SLOW_IDLE;
          end
        end
        LS_SUSPEND: begin
          if (activity || wake_in) ex_start = 1'b1;
        end
        default: st_d = LS_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LS_ACTIVE;
    else        st_q <= st_d;
  end

  assign link_state    = st_q;
  assign wake_req      = ex_busy;
  assign pll_en        = (st_q == LS_ACTIVE) || (st_q == LS_FAST_IDLE) || ex_busy;
  assign dev_suspended = (st_q == LS_SUSPEND);
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] link_state,
  input logic       pll_en,
  input logic       wake_req,
  input logic       partner_ack,
  input logic       partner_rej,
  input logic       sw_suspend,
  input logic       wake_in,
  input logic       xfer_pending
);
  assert_pll_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state[1] && !wake_req) |-> !pll_en);

  assert_pending_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !wake_req && xfer_pending && !sw_suspend) |=> (link_state == 2'd0));

  assert_exit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req) |-> (link_state == 2'd0));

  assert_susp_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd3 && !wake_req && wake_in) |=> (wake_req && link_state == 2'd3));

  assert_suspend_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !wake_req && sw_suspend) |=> (link_state == 2'd3));

  assert_handshake_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(partner_ack && partner_rej));

  assert_ack_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    partner_ack |-> (link_state == 2'd1 || link_state == 2'd2));
endmodule

bind link_pm_ctrl lpm_checker u_lpm_checker (
  .clk(clk), .rst_n(rst_n), .link_state(link_state), .pll_en(pll_en),
  .wake_req(wake_req), .partner_ack(partner_ack), .partner_rej(partner_rej),
  .sw_suspend(sw_suspend), .wake_in(wake_in), .xfer_pending(xfer_pending)
);

// File: tb/tb_link_pm_ctrl.sv
module tb_link_pm_ctrl;
  localparam int TW = 16;
  localparam int LW = 8;

  logic clk = 0, rst_n = 0;
  logic tv = 0, ts = 0, pend = 0, txq = 0, preq = 0, sus = 0, wk = 0;
  logic [1:0] lvl = 0;
  logic [TW-1:0] u1 = 0, u2 = 0;
  logic [LW-1:0] lf = 0, ls = 0;
  logic [1:0] link_state;
  logic pll_en, wake_req, dev_suspended, partner_ack, partner_rej;

  int checks = 0, errors = 0;
  int m_st, m_busy, m_ecnt, m_idle, m_ack, m_rej;

  always #10 clk = ~clk;

  link_pm_ctrl #(.TW(TW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .traffic_vld(tv), .traffic_is_ts(ts),
    .xfer_pending(pend), .tx_queued(txq), .partner_req_vld(preq),
    .partner_req_lvl(lvl), .sw_suspend(sus), .wake_in(wk),
    .u1_timeout(u1), .u2_timeout(u2), .exit_lat_fast(lf), .exit_lat_slow(ls),
    .link_state(link_state), .pll_en(pll_en), .wake_req(wake_req),
    .dev_suspended(dev_suspended), .partner_ack(partner_ack), .partner_rej(partner_rej)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v == 65535) ? v : v + 1;
  endfunction

  task automatic model_reset();
    m_st = 0; m_busy = 0; m_ecnt = 0; m_idle = 0; m_ack = 0; m_rej = 0;
  endtask

  task automatic model_step();
    int act, nx;
    act = (tv && !ts) ? 1 : 0;
    m_ack = 0; m_rej = 0;
    if (m_busy != 0) begin
      if (m_ecnt == 0) begin m_st = 0; m_busy = 0; m_idle = 0; end
      else m_ecnt--;
    end else begin
      case (m_st)
        0: begin
          if (sus) begin m_st = 3; m_idle = 0; end
          else if (preq) begin
            m_idle = 0;
            if ((lvl == 1 || lvl == 2) && !txq && !pend) begin m_ack = 1; m_st = int'(lvl); end
            else m_rej = 1;
          end else if (act != 0 || pend) m_idle = 0;
          else begin
            nx = sat_inc(m_idle); m_idle = nx;
            if (u1 != 0 && nx >= int'(u1)) m_st = 1;
            else if (u1 == 0 && u2 != 0 && nx >= int'(u2)) m_st = 2;
          end
        end
        1, 2: begin
          if (act != 0 || wk || pend) begin
            m_busy = 1; m_ecnt = (m_st == 1) ? int'(lf) : int'(ls);
          end else if (m_st == 1) begin
            nx = sat_inc(m_idle); m_idle = nx;
            if (u2 != 0 && nx >= int'(u2)) m_st = 2;
          end
        end
        default: if (act != 0 || wk) begin m_busy = 1; m_ecnt = int'(ls); end
      endcase
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "link_state", int'(link_state), m_st);
    chk(tag, "wake_req", int'(wake_req), m_busy);
    chk(tag, "pll_en", int'(pll_en), (m_st <= 1 || m_busy != 0) ? 1 : 0);
    chk(tag, "dev_suspended", int'(dev_suspended), (m_st == 3) ? 1 : 0);
    chk(tag, "partner_ack", int'(partner_ack), m_ack);
    chk(tag, "partner_rej", int'(partner_rej), m_rej);
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    model_step();
    compare(tag);
  endtask

  task automatic quiet();
    tv = 0; ts = 0; pend = 0; txq = 0; preq = 0; sus = 0; wk = 0; lvl = 0;
  endtask

  task automatic idle(input int n, input string tag);
    quiet();
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic pulse_wake(input string tag);
    quiet(); wk = 1; step(tag); wk = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; quiet();
    repeat (3) @(posedge clk);
    #1; rst_n = 1; model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    u1 = 4; u2 = 0; lf = 2; ls = 5;
    do_reset();
    // R1 reset values
    compare("R1");

    // R3 entry to level 1 on exact count; zero timeout disables
    idle(6, "R3");
    chk("R3", "state after timer", int'(link_state), 1);
    pulse_wake("R3"); idle(4, "R3");
    u1 = 0; u2 = 0; idle(20, "R3");
    chk("R3", "no timer entry", int'(link_state), 0);

    // R4 count carried into level 1; direct jump when u1 is zero
    u1 = 3; u2 = 7; idle(10, "R4");
    chk("R4", "reached level 2", int'(link_state), 2);
    // R2 level 2 dwell, pll off
    idle(3, "R2");
    chk("R2", "pll in level 2", int'(pll_en), 0);
    pulse_wake("R8"); idle(8, "R8");
    u1 = 0; u2 = 5; idle(7, "R4");
    pulse_wake("R4"); idle(7, "R4");

    // R5 timestamp traffic does not reset the count or wake
    u1 = 4; u2 = 9;
    for (int i = 0; i < 12; i++) begin
      quiet(); tv = (i % 2 == 0); ts = 1; step("R5");
    end
    chk("R5", "level 2 despite timestamps", int'(link_state), 2);
    quiet(); tv = 1; ts = 0; step("R7"); idle(8, "R8");

    // R6 pending holds level 0, wakes level 1
    for (int i = 0; i < 10; i++) begin quiet(); pend = 1; step("R6"); end
    idle(4, "R6");
    quiet(); pend = 1; step("R6"); idle(5, "R6");

    // R7/R8 exit timing from level 1 (fast) and level 3 (slow)
    idle(4, "R7");
    pulse_wake("R7"); idle(4, "R8");
    quiet(); sus = 1; step("R9"); idle(3, "R9");
    pulse_wake("R7"); idle(7, "R8");

    // R9 suspend ignored outside level 0, has priority
    idle(4, "R9");
    quiet(); sus = 1; step("R9");
    chk("R9", "suspend ignored in level 1", int'(link_state), 1);
    pulse_wake("R9"); idle(3, "R9");
    quiet(); sus = 1; preq = 1; lvl = 1; tv = 1; step("R11");
    idle(2, "R9"); pulse_wake("R9"); idle(7, "R9");

    // R10 partner handshake
    u1 = 0; u2 = 0;
    quiet(); preq = 1; lvl = 2; step("R10"); idle(2, "R10");
    pulse_wake("R10"); idle(7, "R10");
    quiet(); preq = 1; lvl = 1; txq = 1; step("R10"); idle(1, "R10");
    quiet(); preq = 1; lvl = 1; pend = 1; step("R10"); idle(1, "R10");
    quiet(); preq = 1; lvl = 3; step("R10"); idle(1, "R10");
    quiet(); preq = 1; lvl = 0; step("R10"); idle(1, "R10");
    quiet(); preq = 1; lvl = 1; step("R10");
    quiet(); preq = 1; lvl = 2; step("R10");
    chk("R10", "no pulse outside level 0", int'(partner_rej), 0);
    pulse_wake("R10"); idle(4, "R10");

    // R11 random mix, config changed in segments
    for (int seg = 0; seg < 6; seg++) begin
      u1 = 16'($urandom % 9); u2 = 16'($urandom % 20);
      lf = 8'($urandom % 4); ls = 8'($urandom % 7);
      for (int i = 0; i < 500; i++) begin
        tv   = ($urandom % 8) == 0;
        ts   = ($urandom % 2) == 0;
        pend = ($urandom % 14) == 0;
        txq  = ($urandom % 3) == 0;
        preq = ($urandom % 10) == 0;
        lvl  = 2'($urandom % 4);
        sus  = ($urandom % 40) == 0;
        wk   = ($urandom % 25) == 0;
        step("R11");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule